// File: doc/BRIEF.md
# Clock Generator Configuration Slave (Two-Wire Block Protocol)

This block is the serial configuration port of a clock synthesizer. It listens on a two-wire serial bus (SCL, open-drain SDA), recognises its own device address and keeps a small bank of 8-bit control registers. Their contents are presented in parallel to the rest of the synthesizer: frequency selection, output enables and similar controls. All lines are oversampled on a system clock that runs at least ten times faster than SCL.

Register access always uses block transfers with no register pointer.

- **Write:** after the write address, the host sends a command code and a byte count. Both are acknowledged and discarded. The data bytes that follow fill the registers from index 0 upward, and the host may stop after any whole byte.
- **Read:** the slave first returns a byte count of six, then registers 0 to 5 in order.
- **Reserved register:** register 6 keeps its power-on value and is never written.
- **Restarts:** a repeated start at any point restarts address reception.

Top module: `clkcfg_slave`

## Requirements
- R1: After reset the register bank holds index0=0x00, index1=0x0F, index2=0xFF, index3=0xFF, index4=0xFF, index5=0xEB, index6=0x06, and SDA is not pulled low.
- R2: An address byte of 0xD2 (write) or 0xD3 (read) is acknowledged by pulling SDA low during the ninth SCL pulse. Bits are sent MSB first, and bit 0 of the address byte selects read (1).
- R3: Any other address byte is not acknowledged, and SDA stays released for the rest of that transfer, including the following bytes, until the next start.
- R4: In a write, the two bytes that follow the address are acknowledged and change no register.
- R5: Write data bytes go to registers 0, 1, 2… in arrival order, each one acknowledged. A stop after any byte keeps the bytes already written and leaves the higher registers unchanged.
- R6: Data bytes aimed at register 6 or beyond are acknowledged, and register 6 never changes.
- R7: A read returns 0x06 first and then registers 0 to 5, MSB first. Any further byte reads 0xFF.
- R8: When the host does not acknowledge a read byte, the slave releases SDA and drives nothing until the next start.
- R9: A repeated start in the middle of a transfer restarts address reception, and register loading starts again at register 0.
- R10: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. A stop returns the slave to idle with SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10x SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| cfg_o | output | NREGS*8 | Register bank, register k in bits [8k+7:8k] |

## Verification
The hardest conditions to reach are those in the middle of a transfer:

- a host NACK followed by further SCL pulses without a new start;
- a repeated start that lands while the write index is already past the first data byte.

The bench drives the bus bit by bit through an open-drain model that combines the host's drive with the slave's pull. This lets it keep clocking after a NACK and see 0xFF on a released line. It can also place a repeated start right after a data acknowledge, and then show through the parallel outputs that loading began again at register 0.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RX,
    PH_RX_ACK,
    PH_TX,
    PH_TX_ACK
  } phase_t;

  function automatic logic [7:0] reg_default(input int unsigned idx);
    case (idx)
      0:       reg_default = 8'h00;
      1:       reg_default = 8'h0F;
      2, 3, 4: reg_default = 8'hFF;
      5:       reg_default = 8'hEB;
      6:       reg_default = 8'h06;
      default: reg_default = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/clkcfg_line_sync.sv
module clkcfg_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [1:0] scl_ff, sda_ff;
  logic       scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= 2'b11;
      sda_ff <= 2'b11;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[0], scl_i};
      sda_ff <= {sda_ff[0], sda_i};
      scl_p  <= scl_ff[1];
      sda_p  <= sda_ff[1];
    end
  end

  assign sda_s     = sda_ff[1];
  assign scl_rise  = scl_ff[1] & ~scl_p;
  assign scl_fall  = ~scl_ff[1] & scl_p;
  assign start_evt = scl_ff[1] & scl_p & sda_p & ~sda_ff[1];
  assign stop_evt  = scl_ff[1] & scl_p & ~sda_p & sda_ff[1];
endmodule

// File: rtl/clkcfg_regbank.sv
module clkcfg_regbank #(
  parameter int NREGS    = 7,
  parameter int RSVD_IDX = 6,
  localparam int IDXW    = $clog2(NREGS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IDXW-1:0]      wr_idx,
  input  logic [7:0]           wr_data,
  input  logic [IDXW-1:0]      rd_idx,
  output logic [7:0]           rd_data,
  output logic [NREGS*8-1:0]   regs
);
  logic [7:0] bank [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    if (g == RSVD_IDX) begin : g_fixed
      assign bank[g] = clkcfg_pkg::reg_default(g);
    end else begin : g_rw
      logic [7:0] q;
      logic       ld;
      assign ld = wr_en && (wr_idx == IDXW'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= clkcfg_pkg::reg_default(g);
        else if (ld) q <= wr_data;
      end
      assign bank[g] = q;
    end
    assign regs[g*8 +: 8] = bank[g];
  end

  always_comb begin
    rd_data = 8'hFF;
    for (int k = 0; k < NREGS; k++)
      if (rd_idx == IDXW'(k)) rd_data = bank[k];
  end
endmodule

// File: rtl/clkcfg_proto_fsm.sv
module clkcfg_proto_fsm
  import clkcfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int NREGS    = 7,
  parameter int RSVD_IDX = 6,
  parameter int RD_COUNT = 6,
  localparam int IDXW    = $clog2(NREGS),
  localparam int PTRW    = $clog2(NREGS + RD_COUNT + 3)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sda_s,
  input  logic            scl_rise,
  input  logic            scl_fall,
  input  logic            start_evt,
  input  logic            stop_evt,
  input  logic [7:0]      rd_data,
  output logic [IDXW-1:0] rd_idx,
  output logic            wr_en,
  output logic [IDXW-1:0] wr_idx,
  output logic [7:0]      wr_data,
  output logic            sda_pull,
  output logic            busy
);
  localparam logic [PTRW-1:0] PTR_MAX = {PTRW{1'b1}};

  phase_t          ph_q, ph_d;
  logic [2:0]      bit_q, bit_d;
  logic [7:0]      sh_q, sh_d;
  logic            got_q, got_d;
  logic            adr_q, adr_d;
  logic            rd_q, rd_d;
  logic            oe_q, oe_d;
  logic [PTRW-1:0] idx_q, idx_d;
  logic [PTRW-1:0] widx, ridx, idx_inc;
  logic [7:0]      tx_byte;
  logic            wr_ok;

  assign widx    = idx_q - PTRW'(2);
  assign ridx    = idx_q - PTRW'(1);
  assign idx_inc = (idx_q == PTR_MAX) ? idx_q : idx_q + PTRW'(1);
  assign wr_ok   = (idx_q >= PTRW'(2)) && (widx < PTRW'(NREGS)) &&
                   (widx != PTRW'(RSVD_IDX));
  assign rd_idx  = IDXW'(ridx);
  assign wr_idx  = IDXW'(widx);
  assign wr_data = sh_q;

  always_comb begin
    if (idx_q == '0)                 tx_byte = 8'(RD_COUNT);
    else if (ridx < PTRW'(RD_COUNT)) tx_byte = rd_data;
    else                             tx_byte = 8'hFF;
  end

  always_comb begin
    ph_d  = ph_q;  bit_d = bit_q; sh_d = sh_q; got_d = got_q;
    adr_d = adr_q; rd_d  = rd_q;  idx_d = idx_q;
    wr_en = 1'b0;
    if (start_evt) begin
      ph_d = PH_RX; bit_d = '0; got_d = 1'b0;
      adr_d = 1'b1; rd_d = 1'b0; idx_d = '0;
    end else if (stop_evt) begin
      ph_d = PH_IDLE;
    end else begin
      case (ph_q)
        PH_RX: begin
          if (scl_rise) begin
            sh_d  = {sh_q[6:0], sda_s};
            bit_d = bit_q + 3'd1;
            if (bit_q == 3'd7) got_d = 1'b1;
          end else if (scl_fall && got_q) begin
            got_d = 1'b0;
            if (adr_q) begin
              if (sh_q[7:1] == DEV_ADDR) begin
                adr_d = 1'b0;
                rd_d  = sh_q[0];
                ph_d  = PH_RX_ACK;
              end else begin
                ph_d = PH_IDLE;
              end
            end else begin
              wr_en = wr_ok;
              idx_d = idx_inc;
              ph_d  = PH_RX_ACK;
            end
          end
        end
        PH_RX_ACK: begin
          if (scl_fall) begin
            bit_d = '0;
            if (rd_q) begin
              ph_d = PH_TX;
              sh_d = tx_byte;
            end else begin
              ph_d = PH_RX;
            end
          end
        end
        PH_TX: begin
          if (scl_fall) begin
            sh_d  = {sh_q[6:0], 1'b1};
            bit_d = bit_q + 3'd1;
            if (bit_q == 3'd7) begin
              ph_d  = PH_TX_ACK;
              idx_d = idx_inc;
              got_d = 1'b0;
            end
          end
        end
        PH_TX_ACK: begin
          if (scl_rise) begin
            got_d = sda_s;
          end else if (scl_fall) begin
            if (got_q) begin
              ph_d = PH_IDLE;
            end else begin
              ph_d  = PH_TX;
              sh_d  = tx_byte;
              bit_d = '0;
            end
            got_d = 1'b0;
          end
        end
        default: ;
      endcase
    end
    oe_d = (ph_d == PH_RX_ACK) || ((ph_d == PH_TX) && !sh_d[7]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      bit_q <= '0;
      sh_q  <= '0;
      got_q <= 1'b0;
      adr_q <= 1'b0;
      rd_q  <= 1'b0;
      oe_q  <= 1'b0;
      idx_q <= '0;
    end else begin
      ph_q  <= ph_d;
      bit_q <= bit_d;
      sh_q  <= sh_d;
      got_q <= got_d;
      adr_q <= adr_d;
      rd_q  <= rd_d;
      oe_q  <= oe_d;
      idx_q <= idx_d;
    end
  end

  assign sda_pull = oe_q;
  assign busy     = (ph_q != PH_IDLE);
endmodule

// File: rtl/clkcfg_slave.sv
module clkcfg_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int NREGS    = 7,
  parameter int RSVD_IDX = 6,
  parameter int RD_COUNT = 6,
  localparam int IDXW    = $clog2(NREGS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_pull_o,
  output logic [NREGS*8-1:0] cfg_o
);
  logic [1:0]      rst_ff;
  logic            rst_sn;
  logic            sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic [7:0]      rd_data, wr_data;
  logic [IDXW-1:0] rd_idx, wr_idx;
  logic            wr_en, busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff <= 2'b00;
    else        rst_ff <= {rst_ff[0], 1'b1};
  end
  assign rst_sn = rst_ff[1];

  clkcfg_line_sync u_sync (
    .clk(clk), .rst_n(rst_sn), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  clkcfg_proto_fsm #(
    .DEV_ADDR(DEV_ADDR), .NREGS(NREGS), .RSVD_IDX(RSVD_IDX), .RD_COUNT(RD_COUNT)
  ) u_fsm (
    .clk(clk), .rst_n(rst_sn), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt),
    .rd_data(rd_data), .rd_idx(rd_idx), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .sda_pull(sda_pull_o), .busy(busy)
  );

  clkcfg_regbank #(.NREGS(NREGS), .RSVD_IDX(RSVD_IDX)) u_bank (
    .clk(clk), .rst_n(rst_sn), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data), .regs(cfg_o)
  );
endmodule

// File: rtl/clkcfg_slave_chk.sv
module clkcfg_slave_chk #(
  parameter int NREGS    = 7,
  parameter int RSVD_IDX = 6,
  localparam int IDXW    = $clog2(NREGS)
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NREGS*8-1:0] cfg_o,
  input logic               sda_pull_o,
  input logic               busy,
  input logic               start_evt,
  input logic               stop_evt,
  input logic               wr_en,
  input logic [IDXW-1:0]    wr_idx
);
  logic [NREGS*8-1:0] dflt;
  for (genvar g = 0; g < NREGS; g++) begin : g_d
    assign dflt[g*8 +: 8] = clkcfg_pkg::reg_default(g);
  end

  AST_RESET_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (cfg_o == dflt) && !sda_pull_o); // R1
  AST_NO_PULL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull_o |-> busy); // R3
  AST_RSVD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(cfg_o[RSVD_IDX*8 +: 8])); // R6
  AST_WRITE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_idx) < NREGS) && (int'(wr_idx) != RSVD_IDX)); // R6
  AST_START_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> busy && !sda_pull_o); // R9
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !busy && !sda_pull_o); // R10
endmodule

bind clkcfg_slave clkcfg_slave_chk #(.NREGS(NREGS), .RSVD_IDX(RSVD_IDX)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_o(cfg_o), .sda_pull_o(sda_pull_o),
  .busy(busy), .start_evt(start_evt), .stop_evt(stop_evt),
  .wr_en(wr_en), .wr_idx(wr_idx)
);

// File: tb/sim_clkcfg_slave.sv
module sim_clkcfg_slave;
  localparam int Q = 100;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, scl, sda_h, sda_pull;
  logic [55:0] cfg;
  wire         sda_bus = sda_h & ~sda_pull;

  clkcfg_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_pull_o(sda_pull), .cfg_o(cfg)
  );

  typedef struct { string tag; logic [7:0] val; } item_t;
  item_t exp_q[$];
  item_t act_q[$];
  int    checks = 0, failures = 0;
  bit    done = 0;

  task automatic cmp(input string tag, input logic [7:0] a, input logic [7:0] e);
    checks++;
    if (a !== e) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, a, e);
    end
  endtask

  initial forever begin
    @(negedge clk);
    while (act_q.size() > 0 && exp_q.size() > 0) begin
      item_t a, e;
      a = act_q.pop_front();
      e = exp_q.pop_front();
      cmp(e.tag, a.val, e.val);
    end
  end

  task automatic bus_start();
    sda_h = 1'b1; #Q; scl = 1'b1; #Q; sda_h = 1'b0; #Q; scl = 1'b0; #Q;
  endtask

  task automatic bus_stop();
    sda_h = 1'b0; #Q; scl = 1'b1; #Q; sda_h = 1'b1; #Q;
  endtask

  task automatic wr(input logic [7:0] b, input logic exp_ack, input string tag);
    logic ack;
    exp_q.push_back('{tag, {7'd0, exp_ack}});
    for (int i = 7; i >= 0; i--) begin
      sda_h = b[i]; #Q; scl = 1'b1; #Q; scl = 1'b0;
    end
    sda_h = 1'b1; #Q; scl = 1'b1; #(Q/2); ack = ~sda_bus; #(Q/2); scl = 1'b0;
    act_q.push_back('{"ack", {7'd0, ack}});
  endtask

  task automatic rd(input logic [7:0] exp_b, input logic host_ack, input string tag);
    logic [7:0] b;
    exp_q.push_back('{tag, exp_b});
    sda_h = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      #Q; scl = 1'b1; #(Q/2); b[i] = sda_bus; #(Q/2); scl = 1'b0;
    end
    sda_h = ~host_ack; #Q; scl = 1'b1; #Q; scl = 1'b0;
    act_q.push_back('{"rd", b});
  endtask

  task automatic chk_reg(input int idx, input logic [7:0] e, input string tag);
    cmp(tag, cfg[idx*8 +: 8], e);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; scl = 1'b1; sda_h = 1'b1;
    #100; rst_n = 1'b1; #200;

    // R1 reset values and released line
    chk_reg(0, 8'h00, "R1 reg0"); chk_reg(1, 8'h0F, "R1 reg1");
    chk_reg(2, 8'hFF, "R1 reg2"); chk_reg(3, 8'hFF, "R1 reg3");
    chk_reg(4, 8'hFF, "R1 reg4"); chk_reg(5, 8'hEB, "R1 reg5");
    chk_reg(6, 8'h06, "R1 reg6"); cmp("R1 sda released", {7'd0, sda_bus}, 8'h01);

    // R2 R4 R5 partial write
    bus_start();
    wr(8'hD2, 1'b1, "R2 write addr ack");
    wr(8'h55, 1'b1, "R4 cmd ack");
    wr(8'h07, 1'b1, "R4 count ack");
    wr(8'hA1, 1'b1, "R5 data0 ack");
    wr(8'hB2, 1'b1, "R5 data1 ack");
    bus_stop(); #200;
    chk_reg(0, 8'hA1, "R5 reg0"); chk_reg(1, 8'hB2, "R5 reg1");
    chk_reg(2, 8'hFF, "R5 reg2 untouched"); chk_reg(5, 8'hEB, "R4 reg5 untouched");
    cmp("R10 released after stop", {7'd0, sda_bus}, 8'h01);

    // R5 R6 full write past the end
    bus_start();
    wr(8'hD2, 1'b1, "R2 write addr ack");
    wr(8'h00, 1'b1, "R4 cmd ack");
    wr(8'h08, 1'b1, "R4 count ack");
    for (int k = 0; k < 8; k++) wr(8'h11 * (k + 1), 1'b1, "R6 data ack");
    bus_stop(); #200;
    for (int k = 0; k < 6; k++) chk_reg(k, 8'h11 * (k + 1), "R5 full reg");
    chk_reg(6, 8'h06, "R6 reserved kept");

    // R3 foreign address
    bus_start();
    wr(8'hA0, 1'b0, "R3 foreign addr nack");
    wr(8'h00, 1'b0, "R3 no ack after mismatch");
    bus_stop(); #200;
    chk_reg(0, 8'h11, "R3 reg0 unchanged");

    // R7 block read
    bus_start();
    wr(8'hD3, 1'b1, "R2 read addr ack");
    rd(8'h06, 1'b1, "R7 byte count");
    for (int k = 0; k < 6; k++) rd(8'h11 * (k + 1), 1'b1, "R7 reg data");
    rd(8'hFF, 1'b0, "R7 past end");
    bus_stop(); #200;

    // R8 host NACK releases the line
    bus_start();
    wr(8'hD3, 1'b1, "R2 read addr ack");
    rd(8'h06, 1'b1, "R7 byte count");
    rd(8'h11, 1'b0, "R7 reg0 then nack");
    rd(8'hFF, 1'b0, "R8 released after nack");
    bus_stop(); #200;

    // R9 repeated start restarts at register 0
    bus_start();
    wr(8'hD2, 1'b1, "R2 write addr ack");
    wr(8'h00, 1'b1, "R4 cmd ack");
    wr(8'h02, 1'b1, "R4 count ack");
    wr(8'h5A, 1'b1, "R5 data0 ack");
    bus_start();
    wr(8'hD2, 1'b1, "R9 addr after restart");
    wr(8'h00, 1'b1, "R9 cmd ack");
    wr(8'h01, 1'b1, "R9 count ack");
    wr(8'hC3, 1'b1, "R9 data0 ack");
    bus_stop(); #200;
    chk_reg(0, 8'hC3, "R9 reg0 reloaded"); chk_reg(1, 8'h22, "R9 reg1 kept");

    bus_start();
    wr(8'hD2, 1'b1, "R2 write addr ack");
    wr(8'h00, 1'b1, "R4 cmd ack");
    bus_start();
    wr(8'hD3, 1'b1, "R9 read addr after restart");
    rd(8'h06, 1'b1, "R9 byte count");
    rd(8'hC3, 1'b0, "R9 reg0");
    bus_stop(); #500;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule